// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block turns a frame held in a transmit buffer into a nibble-wide transmit stream of the kind a media-independent interface expects. For each frame it sends a preamble and start delimiter, then the buffered bytes, then zero-valued padding up to the minimum frame length, and then a CRC-32 frame check sequence unless software has asked to supply its own. Every byte leaves as two nibbles, low nibble first, and the transmit-enable output stays high for the whole frame.

A transmit-enable register decides whether a new frame may begin. Software writes it. Clearing it during a frame only stops the next frame from starting, so the frame in flight always completes. A signal-quality test error can stop the transmitter: when the stop option is set, the error clears the enable bit and raises a sticky error flag, and a later write of 1 to the enable bit clears that flag. A loopback mode sends the stream to a separate internal output pair and holds the external pins idle.

The buffer side is a simple valid/ready byte stream. The byte count is given alongside it, and `buf_last` marks the final byte. The byte count is the real data length only; the pad bytes the block inserts are never included in it.

Top module: `eth_tx_formatter`

## Requirements
- R1: After reset, `mii_txd` is 0, `mii_txen` is 0, `loop_txen` is 0, `frame_done` is 0, `tx_on` is 0 and `tx_err` is 0.
- R2: Each frame starts with seven bytes of 0x55 followed by one byte of 0xD5. Each byte goes out low nibble first, one nibble per cycle, and the transmit enable stays high without a gap from the first preamble nibble to the last nibble of the frame.
- R3: After the delimiter, exactly `buf_len` buffer bytes are sent in order. `buf_len` is sampled when the frame starts and must be 1 or more. `buf_ready` accepts one byte every two cycles, and `buf_last` accompanies the byte numbered `buf_len`.
- R4: With `pad_en` = 1, a short frame is extended with 0x00 bytes until data plus pad reaches 60 bytes when a CRC is appended, or 64 bytes when it is not. Frames already at or above that length get no pad. With `pad_en` = 0, no pad is added.
- R5: With `crc_off` = 0, four FCS bytes follow the data and pad. They are the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) computed over the data and pad, and they are sent least significant byte first.
- R6: With `crc_off` = 1, no FCS is sent, so the frame ends with the last data or pad byte.
- R7: A write of 0 to the enable bit (`cfg_wr` = 1, `cfg_en` = 0) during a frame lets that frame finish. No new frame starts, even with `buf_valid` high, until a write of 1 is made.
- R8: A cycle with `sqe_err` = 1 and `stop_on_sqe` = 1 clears `tx_on` and sets `tx_err`. This takes priority over a write in the same cycle. No frame then starts until a write of 1, and that write also clears `tx_err`.
- R9: With `stop_on_sqe` = 0, `sqe_err` has no effect on `tx_on`, on `tx_err` or on the frames that follow.
- R10: While `loopback` = 1, `mii_txd` is 0 and `mii_txen` is 0, and the frame appears unchanged on `loop_txd`/`loop_txen`. While `loopback` = 0, `loop_txen` is 0.
- R11: `frame_done` is high for exactly one cycle, in the cycle that carries the frame's last nibble. At least 24 idle cycles separate the end of one frame from the start of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_en | input | 1 | Value written to the enable bit |
| pad_en | input | 1 | Pad short frames with zero bytes |
| crc_off | input | 1 | Suppress the appended FCS |
| stop_on_sqe | input | 1 | Let an SQE test error stop the transmitter |
| loopback | input | 1 | Route the stream internally and idle the pins |
| sqe_err | input | 1 | SQE test error indication |
| buf_valid | input | 1 | Buffer byte available |
| buf_data | input | 8 | Buffer byte |
| buf_len | input | 11 | Frame data byte count, excluding pad |
| buf_last | input | 1 | Marks the final buffer byte |
| buf_ready | output | 1 | Buffer byte consumed this cycle |
| mii_txd | output | 4 | External transmit nibble |
| mii_txen | output | 1 | External transmit enable |
| loop_txd | output | 4 | Loopback transmit nibble |
| loop_txen | output | 1 | Loopback transmit enable |
| frame_done | output | 1 | One-cycle pulse on the last nibble of a frame |
| tx_on | output | 1 | Current value of the transmit enable bit |
| tx_err | output | 1 | Sticky flag for an SQE stop |

## Verification
The hardest case to reach from the ports is a disable that lands in the middle of a frame. It only shows its effect because a second frame is already waiting. To set it up, the bench writes 0 while payload bytes are still being taken. It then holds a new frame valid for a hundred cycles and watches that no enable appears on either output before it writes 1 again. The SQE stop uses the same hold-and-release pattern, so that the sticky flag and the blocked start are both seen. The pad boundary is covered by lengths on both sides of the minimum, with the CRC both on and off.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;
    localparam int PRE_BYTES = 8;
    localparam int FCS_BYTES = 4;
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_DATA, S_PAD, S_FCS, S_GAP
    } seq_e;

    typedef struct packed {
        logic [3:0] nib;
        logic       en;
        logic       done;
    } txo_t;

    function automatic logic [31:0] crc_step(input logic [31:0] crc, input logic [7:0] b);
        logic [31:0] c;
        c = crc ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/eth_txf_crc.sv
module eth_txf_crc (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    import eth_txf_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= 32'hFFFFFFFF;
        else if (upd)   crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/eth_txf_ctl.sv
module eth_txf_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic cfg_en,
    input  logic sqe_err,
    input  logic stop_on_sqe,
    output logic en_q,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (sqe_err && stop_on_sqe) begin
            en_q  <= 1'b0;
            err_q <= 1'b1;
        end else if (cfg_wr) begin
            en_q <= cfg_en;
            if (cfg_en) err_q <= 1'b0;
        end
    end

    assert_err_clears_en_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> !en_q);
    assert_sqe_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (sqe_err && !stop_on_sqe && !cfg_wr) |=> ($stable(en_q) && $stable(err_q)));
endmodule

// File: rtl/eth_txf_seq.sv
module eth_txf_seq #(
    parameter int LEN_W     = 11,
    parameter int MIN_FRAME = 64,
    parameter int IFG_NIBS  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_on,
    input  logic             pad_en,
    input  logic             crc_off,
    input  logic             buf_valid,
    input  logic [7:0]       buf_data,
    input  logic [LEN_W-1:0] buf_len,
    input  logic             buf_last,
    output logic             buf_ready,
    input  logic [31:0]      crc_val,
    output logic             crc_clr,
    output logic             crc_upd,
    output logic [7:0]       crc_byte,
    output eth_txf_pkg::txo_t txo
);
    import eth_txf_pkg::*;

    localparam logic [LEN_W-1:0] TGT_FCS  = LEN_W'(MIN_FRAME - FCS_BYTES);
    localparam logic [LEN_W-1:0] TGT_RAW  = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] PRE_LAST = LEN_W'(PRE_BYTES - 1);
    localparam logic [LEN_W-1:0] FCS_LAST = LEN_W'(FCS_BYTES - 1);
    localparam logic [LEN_W-1:0] GAP_LAST = LEN_W'(IFG_NIBS - 1);

    seq_e             state;
    logic             phase;
    logic [LEN_W-1:0] cnt, len_q, target;
    logic             pad_q, nocrc_q;
    logic [7:0]       cur_byte;
    logic [31:0]      fcs_sh;
    logic             active, byte_end, go_gap;
    txo_t             txo_q;

    assign target   = nocrc_q ? TGT_RAW : TGT_FCS;
    assign active   = (state == S_PRE) || (state == S_DATA) || (state == S_PAD) || (state == S_FCS);
    assign byte_end = active && phase;
    assign fcs_sh   = ~crc_val >> {cnt[1:0], 3'b000};

    always_comb begin
        case (state)
            S_PRE:   cur_byte = (cnt == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
            S_DATA:  cur_byte = buf_data;
            S_FCS:   cur_byte = fcs_sh[7:0];
            default: cur_byte = 8'h00;
        endcase
    end

    always_comb begin
        go_gap = 1'b0;
        if (byte_end) begin
            case (state)
                S_DATA: go_gap = (cnt == len_q - 1'b1) && nocrc_q && !(pad_q && len_q < target);
                S_PAD:  go_gap = (cnt == target - 1'b1) && nocrc_q;
                S_FCS:  go_gap = (cnt == FCS_LAST);
                default: go_gap = 1'b0;
            endcase
        end
    end

    assign buf_ready = (state == S_DATA) && phase;
    assign crc_clr   = (state == S_IDLE);
    assign crc_upd   = byte_end && ((state == S_DATA) || (state == S_PAD));
    assign crc_byte  = cur_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            phase   <= 1'b0;
            cnt     <= '0;
            len_q   <= '0;
            pad_q   <= 1'b0;
            nocrc_q <= 1'b0;
            txo_q   <= '0;
        end else begin
            txo_q.nib  <= active ? (phase ? cur_byte[7:4] : cur_byte[3:0]) : 4'h0;
            txo_q.en   <= active;
            txo_q.done <= go_gap;
            phase      <= active ? ~phase : 1'b0;
            case (state)
                S_IDLE: if (tx_on && buf_valid) begin
                    state   <= S_PRE;
                    cnt     <= '0;
                    len_q   <= buf_len;
                    pad_q   <= pad_en;
                    nocrc_q <= crc_off;
                end
                S_PRE: if (byte_end) begin
                    cnt <= (cnt == PRE_LAST) ? '0 : cnt + 1'b1;
                    if (cnt == PRE_LAST) state <= S_DATA;
                end
                S_DATA: if (byte_end) begin
                    if (cnt == len_q - 1'b1) begin
                        if (pad_q && len_q < target) begin
                            state <= S_PAD;
                            cnt   <= cnt + 1'b1;
                        end else begin
                            state <= nocrc_q ? S_GAP : S_FCS;
                            cnt   <= '0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PAD: if (byte_end) begin
                    if (cnt == target - 1'b1) begin
                        state <= nocrc_q ? S_GAP : S_FCS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_FCS: if (byte_end) begin
                    cnt <= (cnt == FCS_LAST) ? '0 : cnt + 1'b1;
                    if (cnt == FCS_LAST) state <= S_GAP;
                end
                S_GAP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == GAP_LAST) begin
                        state <= S_IDLE;
                        cnt   <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign txo = txo_q;

    assert_ready_has_data_R3: assert property (@(posedge clk) disable iff (rst)
        buf_ready |-> buf_valid);
    assert_last_at_count_R3: assert property (@(posedge clk) disable iff (rst)
        (buf_ready && buf_last) |-> (cnt == len_q - 1'b1));
    assert_first_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(txo_q.en) |-> (txo_q.nib == 4'h5));
    assert_done_ends_frame_R11: assert property (@(posedge clk) disable iff (rst)
        txo_q.done |=> !txo_q.en);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        txo_q.done |=> !txo_q.done);
endmodule

// File: rtl/eth_tx_formatter.sv
module eth_tx_formatter #(
    parameter int LEN_W     = 11,
    parameter int MIN_FRAME = 64,
    parameter int IFG_NIBS  = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             pad_en,
    input  logic             crc_off,
    input  logic             stop_on_sqe,
    input  logic             loopback,
    input  logic             sqe_err,
    input  logic             buf_valid,
    input  logic [7:0]       buf_data,
    input  logic [LEN_W-1:0] buf_len,
    input  logic             buf_last,
    output logic             buf_ready,
    output logic [3:0]       mii_txd,
    output logic             mii_txen,
    output logic [3:0]       loop_txd,
    output logic             loop_txen,
    output logic             frame_done,
    output logic             tx_on,
    output logic             tx_err
);
    import eth_txf_pkg::*;

    logic        en_q, err_q;
    logic [31:0] crc_val;
    logic        crc_clr, crc_upd;
    logic [7:0]  crc_byte;
    txo_t        txo;

    eth_txf_ctl u_ctl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .sqe_err(sqe_err), .stop_on_sqe(stop_on_sqe),
        .en_q(en_q), .err_q(err_q)
    );

    eth_txf_crc u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .upd(crc_upd),
        .din(crc_byte), .crc(crc_val)
    );

    eth_txf_seq #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .IFG_NIBS(IFG_NIBS)) u_seq (
        .clk(clk), .rst(rst), .tx_on(en_q), .pad_en(pad_en), .crc_off(crc_off),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_len(buf_len),
        .buf_last(buf_last), .buf_ready(buf_ready), .crc_val(crc_val),
        .crc_clr(crc_clr), .crc_upd(crc_upd), .crc_byte(crc_byte), .txo(txo)
    );

    assign mii_txd    = loopback ? 4'h0 : txo.nib;
    assign mii_txen   = loopback ? 1'b0 : txo.en;
    assign loop_txd   = loopback ? txo.nib : 4'h0;
    assign loop_txen  = loopback ? txo.en : 1'b0;
    assign frame_done = txo.done;
    assign tx_on      = en_q;
    assign tx_err     = err_q;

    assert_no_start_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !txo.en) |=> !txo.en);
endmodule

// File: tb/tb_eth_tx_formatter.sv
module tb_eth_tx_formatter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 0, cfg_en = 0, pad_en = 0, crc_off = 0, stop_on_sqe = 0;
    logic        loopback = 0, sqe_err = 0, buf_valid = 0, buf_last = 0;
    logic [7:0]  buf_data = 0;
    logic [10:0] buf_len = 0;
    logic        buf_ready, mii_txen, loop_txen, frame_done, tx_on, tx_err;
    logic [3:0]  mii_txd, loop_txd;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    logic [7:0] exp_b[$];
    string      exp_r[$];

    always #2.5 clk = ~clk;

    eth_tx_formatter dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .pad_en(pad_en),
        .crc_off(crc_off), .stop_on_sqe(stop_on_sqe), .loopback(loopback),
        .sqe_err(sqe_err), .buf_valid(buf_valid), .buf_data(buf_data),
        .buf_len(buf_len), .buf_last(buf_last), .buf_ready(buf_ready),
        .mii_txd(mii_txd), .mii_txen(mii_txen), .loop_txd(loop_txd),
        .loop_txen(loop_txen), .frame_done(frame_done), .tx_on(tx_on), .tx_err(tx_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    endtask

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 13 + seed * 29 + 7) & 8'hFF);
    endfunction

    // Independent bitwise reflected CRC-32
    function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
        logic [31:0] r = 32'hFFFFFFFF;
        foreach (q[i]) begin
            for (int b = 0; b < 8; b++) begin
                if (r[0] ^ q[i][b]) r = (r >> 1) ^ 32'hEDB88320;
                else                r = r >> 1;
            end
        end
        return ~r;
    endfunction

    task automatic push_expected(input int n, input int seed);
        logic [7:0] body[$];
        int tgt;
        logic [31:0] f;
        for (int i = 0; i < 7; i++) begin exp_b.push_back(8'h55); exp_r.push_back("R2"); end
        exp_b.push_back(8'hD5); exp_r.push_back("R2");
        for (int i = 0; i < n; i++) begin
            body.push_back(pay(i, seed)); exp_b.push_back(pay(i, seed)); exp_r.push_back("R3");
        end
        tgt = crc_off ? 64 : 60;
        if (pad_en) begin
            for (int i = n; i < tgt; i++) begin
                body.push_back(8'h00); exp_b.push_back(8'h00); exp_r.push_back("R4");
            end
        end
        if (!crc_off) begin
            f = ref_fcs(body);
            for (int k = 0; k < 4; k++) begin
                exp_b.push_back(f[8*k +: 8]); exp_r.push_back("R5");
            end
        end
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk); cfg_wr = 1; cfg_en = v;
        @(negedge clk); cfg_wr = 0;
    endtask

    // hold > 0: keep the frame offered while disabled, confirm nothing starts, then enable
    task automatic send(input int n, input int seed, input int hold, input string hreq);
        bit started = 0;
        push_expected(n, seed);
        @(negedge clk);
        buf_valid = 1; buf_len = 11'(n); buf_data = pay(0, seed); buf_last = (n == 1);
        if (hold > 0) begin
            for (int c = 0; c < hold; c++) begin
                @(negedge clk);
                if (mii_txen || loop_txen) started = 1;
            end
            check(!started, hreq, "frame started while disabled", started, 0);
            wr_en(1'b1);
        end
        for (int i = 0; i < n; i++) begin
            while (!buf_ready) @(negedge clk);
            @(negedge clk);
            if (i + 1 < n) begin
                buf_data = pay(i + 1, seed); buf_last = (i + 2 == n);
            end else begin
                buf_valid = 0; buf_last = 0;
            end
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (!frame_done && t < 3000) begin @(negedge clk); t++; end
        check(t < 3000, "R11", "frame_done seen", t, 0);
        @(negedge clk);
    endtask

    // Scoreboard monitor
    bit         have_lo = 0;
    logic [3:0] lo_nib;
    int         idle = 1000;
    bit         prev_act = 0;
    bit         seen = 0;
    always @(negedge clk) begin
        logic act;
        logic [3:0] nib;
        logic [7:0] got;
        if (!rst) begin
            act = loopback ? loop_txen : mii_txen;
            nib = loopback ? loop_txd : mii_txd;
            if (loopback && loop_txen)
                check(mii_txen == 0 && mii_txd == 0, "R10", "pins not idle in loopback",
                      {mii_txen, mii_txd}, 0);
            if (!loopback)
                check(loop_txen == 0, "R10", "loop output active without loopback", loop_txen, 0);
            if (act && !prev_act && seen)
                check(idle >= 24, "R11", "inter-frame gap", idle, 24);
            if (act) begin
                if (!have_lo) begin
                    lo_nib = nib; have_lo = 1;
                end else begin
                    got = {nib, lo_nib}; have_lo = 0;
                    if (exp_b.size() == 0) check(0, "R3", "unexpected byte", got, 0);
                    else check(got == exp_b[0], exp_r[0], "byte", got, exp_b[0]);
                    if (exp_b.size() != 0) begin void'(exp_b.pop_front()); void'(exp_r.pop_front()); end
                end
                idle = 0; seen = 1;
            end else begin
                if (prev_act) check(!have_lo, "R2", "odd nibble count", have_lo, 0);
                idle++;
            end
            if (frame_done) begin
                check(act && !have_lo && exp_b.size() == 0, "R11", "done on last nibble",
                      exp_b.size(), 0);
            end
            prev_act = act;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R11", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(mii_txd == 0 && mii_txen == 0 && loop_txen == 0 && frame_done == 0,
              "R1", "reset outputs", {mii_txd, mii_txen, loop_txen, frame_done}, 0);
        check(tx_on == 0 && tx_err == 0, "R1", "reset status", {tx_on, tx_err}, 0);

        wr_en(1'b1);
        // R4 / R5: padding with CRC, boundaries around 60
        pad_en = 1; crc_off = 0;
        send(1, 1, 0, "");  wait_done();
        send(59, 2, 0, ""); wait_done();
        send(60, 3, 0, ""); wait_done();
        send(70, 4, 0, ""); wait_done();
        // R4: pad disabled
        pad_en = 0;
        send(10, 5, 0, ""); wait_done();
        // R6: no FCS, pad to 64 and unpadded
        crc_off = 1; pad_en = 1;
        send(20, 6, 0, ""); wait_done();
        pad_en = 0;
        send(5, 7, 0, ""); wait_done();
        // R7: disable mid-frame, frame completes, next held
        crc_off = 0; pad_en = 1;
        fork
            send(40, 8, 0, "");
            begin repeat (60) @(negedge clk); wr_en(1'b0); end
        join
        wait_done();
        check(tx_on == 0, "R7", "enable cleared", tx_on, 0);
        send(8, 9, 100, "R7"); wait_done();
        // R8: stop on SQE error
        stop_on_sqe = 1;
        @(negedge clk); sqe_err = 1; cfg_wr = 1; cfg_en = 1;
        @(negedge clk); sqe_err = 0; cfg_wr = 0;
        check(tx_on == 0 && tx_err == 1, "R8", "sqe stop", {tx_on, tx_err}, 2'b01);
        send(12, 10, 50, "R8");
        check(tx_err == 0, "R8", "error cleared by enable write", tx_err, 0);
        wait_done();
        // R9: SQE ignored without stop option
        stop_on_sqe = 0;
        @(negedge clk); sqe_err = 1;
        @(negedge clk); sqe_err = 0;
        @(negedge clk);
        check(tx_on == 1 && tx_err == 0, "R9", "sqe ignored", {tx_on, tx_err}, 2'b10);
        send(16, 11, 0, ""); wait_done();
        // R10: loopback
        loopback = 1;
        send(8, 12, 0, ""); wait_done();
        loopback = 0;
        repeat (30) @(negedge clk);
        check(exp_b.size() == 0, "R3", "scoreboard drained", exp_b.size(), 0);
        report();
    end
endmodule